// File: doc/BRIEF.md
# CRC5 frame code generator and checker

This unit computes a 5-bit check code over a 24-bit serial command or response frame held as three bytes. The low five bits of the frame are the trailing code field. Before the division they are overwritten with a fixed seed, so the code depends only on the upper 19 bits of the frame. The divisor is x^5 + x^4 + x^2 + 1, held as 0x35 with bit 5 as the leading term. The same datapath serves the transmit side, where the produced code is placed in the trailing field, and the receive side, where the code is compared against the trailing field that arrived.

Frames enter on a valid/ready stream together with a mode bit. Mode 0 generates a code. Mode 1 checks a received frame. Results leave on a second valid/ready stream one cycle after acceptance. A frame is taken on any rising clock edge where `in_valid` and `in_ready` are both high. A result is consumed on any edge where `out_valid` and `out_ready` are both high.

Back-pressure works as follows. While a result is held and `out_ready` is low, the result stays frozen and `in_ready` is low. When `out_ready` is high, a new frame can be accepted on the same edge that drains the old result, so throughput is one frame per cycle. The division is fully unrolled, so no computation spans several cycles.

Top module: `crc5f_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0.
- R2: `out_code` equals the remainder of {in_frame[23:5], 5'b00111} divided by x^5+x^4+x^2+1 (0x35) over GF(2), for the accepted frame. An all-zero upper part gives code 0x07.
- R3: in_frame[4:0] has no effect on `out_code`: two frames that differ only in those bits give the same code.
- R4: In check mode (`in_check`=1), `out_err` is 1 exactly when the computed code differs from in_frame[4:0] of the same frame.
- R5: In generate mode (`in_check`=0), `out_err` is 0.
- R6: A frame accepted on an edge makes `out_valid` 1 after that edge, with its code and flag on `out_code` and `out_err`. Latency is one cycle.
- R7: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid`=1 and `out_code` and `out_err` unchanged.
- R8: `in_ready` is 1 exactly when no result is held or `out_ready` is 1, so one frame per cycle is accepted under a free-flowing output.
- R9: A result consumed with no new frame accepted on the same edge leaves `out_valid` at 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Frame can be taken this cycle |
| in_frame | input | 24 | Frame, bits [4:0] are the trailing code field |
| in_check | input | 1 | 0 = generate, 1 = check against bits [4:0] |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 5 | Computed check code |
| out_err | output | 1 | Mismatch flag, check mode only |

## Verification
The bench first sends the all-zero frame, which must return the bare seed 0x07. A design that skipped the seed, or shifted it into the wrong bits, returns 0 or some other value there. It then sends two frames that differ only in their trailing field. A design that divided the raw frame instead of the seeded one returns two different codes.

In check mode the bench sends frames carrying the correct code, then the same frames with each trailing bit flipped in turn. A comparator tied to the wrong bits, or one that was inverted, shows up there. Random frames run under random stalls and random gaps. A register that loaded during a stall, or a ready that ignored the consumer, would drop, duplicate or alter results against the queue model.

// File: rtl/crc5f_pkg.sv
package crc5f_pkg;
  localparam int unsigned FRAME_W_DEF = 24;
  localparam int unsigned CRC_W_DEF   = 5;
  localparam logic [5:0]  POLY_DEF    = 6'h35;
  localparam logic [4:0]  SEED_DEF    = 5'h07;

  typedef enum logic {
    MODE_GEN   = 1'b0,
    MODE_CHECK = 1'b1
  } crc_mode_e;
endpackage

// File: rtl/crc5f_step.sv
// One reduction stage: a (CRC_W+1)-bit window is reduced by the divisor
// when its top bit is set; the low CRC_W bits are the new remainder.
module crc5f_step #(
  parameter int unsigned   CRC_W = 5,
  parameter logic [CRC_W:0] POLY = 6'h35
) (
  input  logic [CRC_W:0]   win,
  output logic [CRC_W-1:0] rem
);
  logic [CRC_W:0] reduced;

  assign reduced = win ^ (win[CRC_W] ? POLY : '0);
  assign rem     = reduced[CRC_W-1:0];
endmodule

// File: rtl/crc5f_core.sv
// Fully unrolled division over the seeded frame.
module crc5f_core #(
  parameter int unsigned     FRAME_W = 24,
  parameter int unsigned     CRC_W   = 5,
  parameter logic [CRC_W:0]   POLY    = 6'h35,
  parameter logic [CRC_W-1:0] SEED    = 5'h07
) (
  input  logic [FRAME_W-1:0] frame,
  output logic [CRC_W-1:0]   code
);
  localparam int unsigned STEPS = FRAME_W - CRC_W - 1;

  logic [FRAME_W-1:0] seeded;
  logic [CRC_W-1:0]   chain [0:STEPS];

  assign seeded = {frame[FRAME_W-1:CRC_W], SEED};

  crc5f_step #(.CRC_W(CRC_W), .POLY(POLY)) u_head (
    .win (seeded[FRAME_W-1 -: CRC_W+1]),
    .rem (chain[0])
  );

  for (genvar i = 0; i < STEPS; i++) begin : g_stage
    crc5f_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
      .win ({chain[i], seeded[FRAME_W-CRC_W-2-i]}),
      .rem (chain[i+1])
    );
  end

  assign code = chain[STEPS];
endmodule

// File: rtl/crc5f_outreg.sv
// Single result register with a valid/ready handshake on both sides.
module crc5f_outreg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end
endmodule

// File: rtl/crc5f_unit.sv
module crc5f_unit
  import crc5f_pkg::*;
#(
  parameter int unsigned     FRAME_W = FRAME_W_DEF,
  parameter int unsigned     CRC_W   = CRC_W_DEF,
  parameter logic [CRC_W:0]   POLY    = POLY_DEF,
  parameter logic [CRC_W-1:0] SEED    = SEED_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               in_check,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CRC_W-1:0]   out_code,
  output logic               out_err
);
  localparam int unsigned RES_W = CRC_W + 1;

  crc_mode_e          mode;
  logic [CRC_W-1:0]   calc;
  logic               mismatch;
  logic [RES_W-1:0]   res_in;
  logic [RES_W-1:0]   res_out;

  assign mode = crc_mode_e'(in_check);

  crc5f_core #(
    .FRAME_W (FRAME_W),
    .CRC_W   (CRC_W),
    .POLY    (POLY),
    .SEED    (SEED)
  ) u_core (
    .frame (in_frame),
    .code  (calc)
  );

  assign mismatch = (mode == MODE_CHECK) && (calc != in_frame[CRC_W-1:0]);
  assign res_in   = {calc, mismatch};

  crc5f_outreg #(.W(RES_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign out_code = res_out[RES_W-1:1];
  assign out_err  = res_out[0];
endmodule

// File: rtl/crc5f_unit_chk.sv
module crc5f_unit_chk #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CRC_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [FRAME_W-1:0] in_frame,
  input logic               in_check,
  input logic               out_valid,
  input logic               out_ready,
  input logic [CRC_W-1:0]   out_code,
  input logic               out_err
);
  AST_FILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R6

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_err)); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_GEN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_check |=> !out_err); // R5

  AST_CHECK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_check |=> out_err == ($past(in_frame[CRC_W-1:0]) != out_code)); // R4

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1
endmodule

bind crc5f_unit crc5f_unit_chk #(.FRAME_W(FRAME_W), .CRC_W(CRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_frame  (in_frame),
  .in_check  (in_check),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .out_err   (out_err)
);

// File: tb/crc5f_unit_tb.sv
module crc5f_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_frame = '0;
  logic        in_check = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [4:0]  out_code;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0] q_code[$];
  logic       q_err[$];
  logic       q_chk[$];
  bit         prev_stall = 1'b0;
  logic [4:0] last_code;
  logic       last_err;

  always #10 clk = ~clk;

  crc5f_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame(in_frame), .in_check(in_check), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_err(out_err)
  );

  // Long division of the seeded frame by x^5+x^4+x^2+1.
  function automatic logic [4:0] ref_code(input logic [23:0] f);
    logic [23:0] d;
    d = {f[23:5], 5'b00111};
    for (int b = 23; b >= 5; b--)
      if (d[b]) d = d ^ (24'h35 << (b - 5));
    return d[4:0];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: compare outputs, apply new inputs, update the model.
  task automatic cycle(input bit v, input logic [23:0] f, input bit chk, input bit ordy);
    bit mv;
    bit exp_rdy;
    @(negedge clk);
    mv = (q_code.size() != 0);
    check(mv ? "R6" : "R9", "out_valid", {31'd0, out_valid}, {31'd0, mv});
    if (mv) begin
      check(prev_stall ? "R7" : "R2", "out_code", {27'd0, out_code}, {27'd0, q_code[0]});
      check(q_chk[0] ? "R4" : "R5", "out_err", {31'd0, out_err}, {31'd0, q_err[0]});
      last_code = out_code;
      last_err  = out_err;
    end
    in_valid  = v;
    in_frame  = f;
    in_check  = chk;
    out_ready = ordy;
    #1;
    exp_rdy = !mv || ordy;
    check("R8", "in_ready", {31'd0, in_ready}, {31'd0, exp_rdy});
    prev_stall = mv && !ordy;
    if (mv && ordy) begin
      void'(q_code.pop_front());
      void'(q_err.pop_front());
      void'(q_chk.pop_front());
    end
    if (v && exp_rdy) begin
      q_code.push_back(ref_code(f));
      q_err.push_back(chk && (ref_code(f) != f[4:0]));
      q_chk.push_back(chk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: cycles got 100000 expected fewer");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [4:0]  code_a;
    logic [23:0] fr;
    // R1: idle during and right after reset
    repeat (3) begin
      @(negedge clk);
      check("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);

    // R2: zero upper part returns the bare seed 0x07
    cycle(1, 24'h000000, 0, 1);
    cycle(0, 24'h0, 0, 1);
    check("R2", "seed-only code", {27'd0, last_code}, 32'h07);
    cycle(1, 24'hFFFFFF, 0, 1);
    cycle(0, 24'h0, 0, 1);

    // R3: trailing bits do not affect the code
    cycle(1, 24'hA5C340, 0, 1);
    cycle(0, 24'h0, 0, 1);
    code_a = last_code;
    cycle(1, 24'hA5C35F, 0, 1);
    cycle(0, 24'h0, 0, 1);
    check("R3", "code with trailing bits set", {27'd0, last_code}, {27'd0, code_a});

    // R4: correct trailing code, then each single-bit corruption
    fr = {19'h3B1E2, 5'b0};
    fr[4:0] = ref_code(fr);
    cycle(1, fr, 1, 1);
    cycle(0, 24'h0, 0, 1);
    check("R4", "err on matching code", {31'd0, last_err}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      cycle(1, fr ^ (24'd1 << k), 1, 1);
      cycle(0, 24'h0, 0, 1);
      check("R4", "err on flipped bit", {31'd0, last_err}, 32'd1);
    end

    // R8: back-to-back at full rate
    for (int k = 0; k < 16; k++) cycle(1, {$urandom} & 24'hFFFFFF, k[0], 1);
    // R7: stall with a held result
    cycle(1, 24'h123456, 0, 0);
    for (int k = 0; k < 4; k++) cycle(1, 24'h654321, 1, 0);
    cycle(0, 24'h0, 0, 1);
    cycle(0, 24'h0, 0, 1);

    // random traffic with gaps and stalls
    for (int k = 0; k < 3000; k++) begin
      bit chk;
      fr  = {$urandom} & 24'hFFFFFF;
      chk = ($urandom % 2) == 0;
      if (chk && ($urandom % 2) == 0) fr[4:0] = ref_code(fr);
      cycle(($urandom % 10) < 7, fr, chk, ($urandom % 10) < 6);
    end
    cycle(0, 24'h0, 0, 1);
    cycle(0, 24'h0, 0, 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule